// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block gathers a set of interrupt source lines and hands them to a processor core one vector at a time. Each source is a level line. A rising level offers that source's vector to the core. The unit accepts the vector only when it is not already holding one. On acceptance it raises a busy flag in its status byte, sets the trap index to the vector trap code and asserts the interrupt request. It also loads three data words for the core to read. The first word carries a fixed tag field and the source number. The other two words are zero.

While a vector is held, new rising edges are discarded. The held vector is released in one of two ways: any source line drops, or the core pulses the clear input after it has read the data words. A small remap stage routes sixteen legacy bus interrupt lines onto five fixed vector numbers and drops the rest. The remapped lines are ORed into the direct source lines before edge detection.

Top module: `ivec_dispatch`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the status byte, `irq_req`, `trap_idx` and all three data words to zero.
- R2: A rising level on any source while busy is clear sets status bit 5 (value 0x20) and `irq_req` on the next clock edge, and sets `trap_idx` to 0x60.
- R3: On acceptance, data word 0 becomes 0x7C0 OR the source number (bits 10:6 hold 0x1F, bits 5:0 hold the source number), and data words 1 and 2 become zero.
- R4: A rising level while busy is set is discarded: busy stays set and data word 0 keeps its value, also after the busy flag is later released.
- R5: A falling level on any source while busy is set clears busy and `irq_req` on the next edge. The data words keep their values.
- R6: Legacy line 1 maps to source 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A. A level on any other legacy line has no effect.
- R7: When several sources rise in the same cycle, the lowest-numbered one is accepted.
- R8: `busy_clr` high while busy is set clears busy and `irq_req` on the next edge. While busy is clear it has no effect, and a later rising edge is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Direct source level lines, bit n is source n |
| legacy_irq | input | 16 | Legacy bus interrupt lines 0 to 15 |
| busy_clr | input | 1 | Core handshake that releases the held vector |
| status | output | 8 | Status byte, bit 5 is busy |
| data0 | output | 64 | Data word 0: tag field and source number |
| data1 | output | 64 | Data word 1, zero on acceptance |
| data2 | output | 64 | Data word 2, zero on acceptance |
| trap_idx | output | 9 | Trap index presented to the core |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bench builds the unit with its default of 48 sources. At that width all five legacy remap targets (0x22 to 0x2B) are present, and so is the top source 47. This exercises the full 6-bit source field of data word 0. The legacy remap and the direct lines share one edge detector, so the bench covers both paths and a wide simultaneous rise that tests the lowest-index pick.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

    localparam int WORD_W      = 64;
    localparam int STAT_W      = 8;
    localparam int BUSY_BIT    = 5;
    localparam int TRAP_W      = 9;
    localparam int SRC_FIELD_W = 6;
    localparam int TAG_LSB     = 6;
    localparam int LEG_N       = 16;

    localparam logic [TRAP_W-1:0] VEC_TRAP  = 9'h060;
    localparam logic [4:0]        FIELD_TAG = 5'h1F;

    typedef enum logic {
        HOLD_IDLE = 1'b0,
        HOLD_BUSY = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w0;
    } ivec_words_t;

    // Destination vector for a legacy line, or -1 when the line is dropped.
    function automatic int legacy_dest(input int line);
        case (line)
            1:       return 'h29;
            4:       return 'h2B;
            6:       return 'h27;
            7:       return 'h22;
            12:      return 'h2A;
            default: return -1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] make_word0(input logic [SRC_FIELD_W-1:0] s);
        return (WORD_W'(FIELD_TAG) << TAG_LSB) | WORD_W'(s);
    endfunction

endpackage

// File: rtl/ivec_legacy_remap.sv
module ivec_legacy_remap
    import ivec_pkg::*;
#(
    parameter int NSRC = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LEG_N-1:0] legacy_irq,
    output logic [NSRC-1:0] mapped
);

    always_comb begin
        mapped = '0;
        for (int i = 0; i < LEG_N; i++) begin
            if (legacy_dest(i) >= 0 && legacy_dest(i) < NSRC) begin
                mapped[legacy_dest(i)] = mapped[legacy_dest(i)] | legacy_irq[i];
            end
        end
    end

    generate
        if (NSRC > 'h2B) begin : g_chk
            // R6: a keyboard-class line reaches its vector
            a_r6_line1_routed: assert property (@(posedge clk) disable iff (rst)
                legacy_irq[1] |-> mapped['h29]);
            // R6: unmapped lines alone produce no vector
            a_r6_unmapped_dropped: assert property (@(posedge clk) disable iff (rst)
                ((legacy_irq & 16'h10D2) == 16'h0) |-> (mapped == '0));
        end
    endgenerate

endmodule

// File: rtl/ivec_edge_pick.sv
module ivec_edge_pick
    import ivec_pkg::*;
#(
    parameter int NSRC = 48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        lvl,
    output logic                   any_rise,
    output logic                   any_fall,
    output logic [SRC_FIELD_W-1:0] pick
);

    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise     = lvl & ~prev_q;
    assign fall     = prev_q & ~lvl;
    assign any_rise = |rise;
    assign any_fall = |fall;

    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (rise[i]) pick = SRC_FIELD_W'(i);
        end
    end

    // R7: the chosen source rose and no lower-numbered source rose
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        any_rise |-> (rise[pick] && ((rise & ~({NSRC{1'b1}} << pick)) == '0)));

endmodule

// File: rtl/ivec_hold_core.sv
module ivec_hold_core
    import ivec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   any_rise,
    input  logic                   any_fall,
    input  logic [SRC_FIELD_W-1:0] pick,
    input  logic                   busy_clr,
    output logic                   busy,
    output logic                   irq_req,
    output logic [TRAP_W-1:0]      trap_idx,
    output ivec_words_t            words
);

    hold_state_e state_q;
    logic        irq_q;
    logic [TRAP_W-1:0] trap_q;
    ivec_words_t words_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOLD_IDLE;
            irq_q   <= 1'b0;
            trap_q  <= '0;
            words_q <= '0;
        end else begin
            case (state_q)
                HOLD_IDLE: begin
                    if (any_rise) begin
                        state_q    <= HOLD_BUSY;
                        irq_q      <= 1'b1;
                        trap_q     <= VEC_TRAP;
                        words_q.w0 <= make_word0(pick);
                        words_q.w1 <= '0;
                        words_q.w2 <= '0;
                    end
                end
                HOLD_BUSY: begin
                    if (any_fall || busy_clr) begin
                        state_q <= HOLD_IDLE;
                        irq_q   <= 1'b0;
                    end
                end
                default: state_q <= HOLD_IDLE;
            endcase
        end
    end

    assign busy     = (state_q == HOLD_BUSY);
    assign irq_req  = irq_q;
    assign trap_idx = trap_q;
    assign words    = words_q;

    // R1: reset leaves nothing pending
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !irq_req && trap_idx == '0));
    // R2: an edge while idle is taken on the next clock
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && any_rise) |=> (busy && irq_req && trap_idx == VEC_TRAP));
    // R3: a held vector always carries the tag field and zero side words
    a_r3_word_format: assert property (@(posedge clk) disable iff (rst)
        busy |-> (words.w0[10:6] == 5'h1F && words.w1 == '0 && words.w2 == '0));
    // R4: while held and not released, contents do not move
    a_r4_held_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !any_fall && !busy_clr) |=> (busy && $stable(words.w0)));
    // R5: a dropping source releases the vector
    a_r5_fall_release: assert property (@(posedge clk) disable iff (rst)
        (busy && any_fall) |=> (!busy && !irq_req));
    // R8: the core handshake releases the vector
    a_r8_clear_release: assert property (@(posedge clk) disable iff (rst)
        (busy && busy_clr) |=> (!busy && !irq_req));

endmodule

// File: rtl/ivec_dispatch.sv
module ivec_dispatch
    import ivec_pkg::*;
#(
    parameter int NSRC = 48
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       src_lvl,
    input  logic [LEG_N-1:0]      legacy_irq,
    input  logic                  busy_clr,
    output logic [STAT_W-1:0]     status,
    output logic [WORD_W-1:0]     data0,
    output logic [WORD_W-1:0]     data1,
    output logic [WORD_W-1:0]     data2,
    output logic [TRAP_W-1:0]     trap_idx,
    output logic                  irq_req
);

    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    initial begin
        if (SRC_W > SRC_FIELD_W) $error("NSRC exceeds the source field width");
    end

    logic [NSRC-1:0]        legacy_vec;
    logic [NSRC-1:0]        all_lvl;
    logic                   any_rise;
    logic                   any_fall;
    logic [SRC_FIELD_W-1:0] pick;
    logic                   busy;
    ivec_words_t            words;

    ivec_legacy_remap #(.NSRC(NSRC)) u_remap (
        .clk        (clk),
        .rst        (rst),
        .legacy_irq (legacy_irq),
        .mapped     (legacy_vec)
    );

    assign all_lvl = src_lvl | legacy_vec;

    ivec_edge_pick #(.NSRC(NSRC)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .lvl      (all_lvl),
        .any_rise (any_rise),
        .any_fall (any_fall),
        .pick     (pick)
    );

    ivec_hold_core u_core (
        .clk      (clk),
        .rst      (rst),
        .any_rise (any_rise),
        .any_fall (any_fall),
        .pick     (pick),
        .busy_clr (busy_clr),
        .busy     (busy),
        .irq_req  (irq_req),
        .trap_idx (trap_idx),
        .words    (words)
    );

    always_comb begin
        status           = '0;
        status[BUSY_BIT] = busy;
    end

    assign data0 = words.w0;
    assign data1 = words.w1;
    assign data2 = words.w2;

    // R2: request and busy flag travel together
    a_r2_req_tracks_busy: assert property (@(posedge clk) disable iff (rst)
        irq_req == status[BUSY_BIT]);

endmodule

// File: tb/ivec_dispatch_test.sv
module ivec_dispatch_test;

    localparam int NSRC = 48;

    typedef struct packed {
        logic [47:0] src;
        logic [15:0] leg;
        logic        clr;
        logic        ebusy;
        logic [15:0] ed0;
        logic [7:0]  req;
    } step_t;

    localparam int NV = 21;
    // R2 R3: accept, R4: ignore while held, R5: release on fall,
    // R7: lowest wins, R6: legacy remap, R8: handshake clear
    localparam step_t VEC [0:NV-1] = '{
        '{48'h0000_0000_0020, 16'h0000, 1'b0, 1'b1, 16'h07C5, 8'd3},
        '{48'h0000_0000_0220, 16'h0000, 1'b0, 1'b1, 16'h07C5, 8'd4},
        '{48'h0000_0000_0200, 16'h0000, 1'b0, 1'b0, 16'h07C5, 8'd5},
        '{48'h0000_0010_0208, 16'h0000, 1'b0, 1'b1, 16'h07C3, 8'd7},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07C3, 8'd5},
        '{48'h0000_0000_0000, 16'h0002, 1'b0, 1'b1, 16'h07E9, 8'd6},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07E9, 8'd5},
        '{48'h0000_0000_0000, 16'h0010, 1'b0, 1'b1, 16'h07EB, 8'd6},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07EB, 8'd5},
        '{48'h0000_0000_0000, 16'h0040, 1'b0, 1'b1, 16'h07E7, 8'd6},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07E7, 8'd5},
        '{48'h0000_0000_0000, 16'h0080, 1'b0, 1'b1, 16'h07E2, 8'd6},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07E2, 8'd5},
        '{48'h0000_0000_0000, 16'h1000, 1'b0, 1'b1, 16'h07EA, 8'd6},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07EA, 8'd5},
        '{48'h0000_0000_0000, 16'hEF2D, 1'b0, 1'b0, 16'h07EA, 8'd6},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07EA, 8'd6},
        '{48'h8000_0000_0000, 16'h0000, 1'b0, 1'b1, 16'h07EF, 8'd3},
        '{48'h8000_0000_0000, 16'h0000, 1'b1, 1'b0, 16'h07EF, 8'd8},
        '{48'h0000_0000_0000, 16'h0000, 1'b0, 1'b0, 16'h07EF, 8'd8},
        '{48'h0000_0000_0001, 16'h0000, 1'b0, 1'b1, 16'h07C0, 8'd2}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_lvl = '0;
    logic [15:0]     legacy_irq = '0;
    logic            busy_clr = 1'b0;
    logic [7:0]      status;
    logic [63:0]     data0, data1, data2;
    logic [8:0]      trap_idx;
    logic            irq_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ivec_dispatch #(.NSRC(NSRC)) uut (
        .clk        (clk),
        .rst        (rst),
        .src_lvl    (src_lvl),
        .legacy_irq (legacy_irq),
        .busy_clr   (busy_clr),
        .status     (status),
        .data0      (data0),
        .data1      (data1),
        .data2      (data2),
        .trap_idx   (trap_idx),
        .irq_req    (irq_req)
    );

    task automatic check_all(input string tag, input logic ebusy, input logic [15:0] ed0,
                             input logic [8:0] etrap);
        logic [7:0] est;
        est = ebusy ? 8'h20 : 8'h00;
        checks++;
        if (status !== est || irq_req !== ebusy || trap_idx !== etrap ||
            data0 !== {48'h0, ed0} || data1 !== 64'h0 || data2 !== 64'h0) begin
            fails++;
            $display("FAIL %s: status=%h irq=%b trap=%h d0=%h d1=%h d2=%h expected status=%h irq=%b trap=%h d0=%h d1=0 d2=0",
                     tag, status, irq_req, trap_idx, data0, data1, data2, est, ebusy, etrap, ed0);
        end
    endtask

    task automatic apply(input logic [47:0] s, input logic [15:0] l, input logic c);
        @(negedge clk);
        src_lvl    = s;
        legacy_irq = l;
        busy_clr   = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset", 1'b0, 16'h0000, 9'h000);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k].src, VEC[k].leg, VEC[k].clr);
            check_all($sformatf("R%0d vector %0d", VEC[k].req, k),
                      VEC[k].ebusy, VEC[k].ed0, 9'h060);
        end

        // R1: reset while a vector is held
        @(negedge clk);
        rst = 1'b1;
        src_lvl = '0;
        @(negedge clk);
        check_all("R1 reset while busy", 1'b0, 16'h0000, 9'h000);
        rst = 1'b0;

        // R8: clear while idle has no effect
        apply('0, 16'h0000, 1'b1);
        check_all("R8 clear while idle", 1'b0, 16'h0000, 9'h000);
        apply(48'h4, 16'h0000, 1'b0);
        check_all("R8 accept after idle clear", 1'b1, 16'h07C2, 9'h060);

        // R7: legacy and direct rise together, direct 0x10 is lower than 0x22
        apply('0, 16'h0000, 1'b0);
        apply(48'h0000_0001_0000, 16'h0080, 1'b0);
        check_all("R7 direct beats legacy", 1'b1, 16'h07D0, 9'h060);

        // R4: rise ignored while held, release by clear, value still the old one
        apply(48'h0000_0001_0001, 16'h0080, 1'b0);
        check_all("R4 ignored rise", 1'b1, 16'h07D0, 9'h060);
        apply(48'h0000_0001_0001, 16'h0080, 1'b1);
        check_all("R4 R8 release keeps data", 1'b0, 16'h07D0, 9'h060);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule